// File: doc/BRIEF.md
# Register-Port Sample Memory Access Controller

This block lets a host move bytes in and out of a byte-wide sample memory one at a time through a single data register. The host sets up the transfer with a few register writes: a memory-type selector, a 16-bit start block, a 16-bit end block and a control byte.

The controller keeps an address pointer counted in nibbles and turns each access to the data register into a synchronous memory read or write. It inserts the two dummy reads that a read sequence needs, and stops at the end of the region. Three level outputs report progress: a ready flag, a sticky end-of-sample flag and a busy flag.

Register map (host address): 0 control, 1 data, 2 flag clear, 3 memory type, 4/5 start block low/high, 6/7 end block low/high. In the control byte, bits [7:5] hold the mode, bit 7 also marks the block busy, bit 5 requests memory access, and bit 0 is a soft reset.

Top module: `smem_port_ctrl`

## Requirements
- R1: After synchronous reset, ready is 1, eos is 0, busy is 0, host_rvalid is 0 and no memory access is issued.
- R2: Control bits [7:5] select the mode: 001 is memory read through the data register, 011 is memory write through the data register. In any other mode a data-register access issues no memory access, and a read of it returns 0.
- R3: A control write with bit 5 set and bit 0 clear loads the nibble pointer with twice the start byte address and arms a dummy counter with the value 2.
- R4: In read mode, while the dummy counter is nonzero, a data read returns 0, issues no memory access, reloads the pointer from the start address and decrements the counter.
- R5: In write mode, a data write made while the dummy counter is armed disarms it and is stored at the start byte address.
- R6: Each real transfer accesses byte pointer/2 and then advances the pointer by 2, so successive transfers touch consecutive bytes.
- R7: When the pointer equals twice the end byte address, a data access transfers nothing and sets eos. Eos stays set until a write to the flag-clear register with bit 0 set.
- R8: Ready drops to 0 for exactly the cycle after a real transfer and is 1 at all other times.
- R9: With memory type 0, block registers are shifted left by 2. With any other type they are shifted left by 5. The end byte address also has (1<<shift)-1 added.
- R10: A control write with bit 0 set clears the mode and busy and leaves ready at 1. A control write with bit 0 clear and bit 7 set sets busy.
- R11: A data-register read is answered one cycle later with host_rvalid high and the byte, or 0, on host_rdata.
- R12: Writes to host addresses 3 to 7 update the memory type, start block and end block as in the register map, in any mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe |
| host_addr | input | 4 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read response data |
| host_rvalid | output | 1 | Read response valid |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 21 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one cycle after the request |
| ready | output | 1 | Transfer-ready flag |
| eos | output | 1 | Sticky end-of-sample flag |
| busy | output | 1 | Busy flag |

## Verification
The assertions take for granted that the host never asserts read and write strobes in the same cycle. They also assume the host leaves at least one idle cycle after each data-register access, so that a transfer never starts while ready is low. The bench drives every access through tasks that hold a strobe for one cycle and then wait a cycle. The memory model returns read data exactly one cycle after each request, as the block assumes.

// File: rtl/smem_pkg.sv
`timescale 1ns/1ps
// Shared constants for the sample memory access controller: host register
// addresses, control-byte bit positions and mode codes.
package smem_pkg;
    typedef logic [2:0] mode_t;

    localparam mode_t MODE_OFF = 3'b000;
    localparam mode_t MODE_RD  = 3'b001;
    localparam mode_t MODE_WR  = 3'b011;

    localparam logic [3:0] RA_CTRL  = 4'd0;
    localparam logic [3:0] RA_DATA  = 4'd1;
    localparam logic [3:0] RA_FCLR  = 4'd2;
    localparam logic [3:0] RA_MTYPE = 4'd3;
    localparam logic [3:0] RA_BEG_L = 4'd4;
    localparam logic [3:0] RA_BEG_H = 4'd5;
    localparam logic [3:0] RA_FIN_L = 4'd6;
    localparam logic [3:0] RA_FIN_H = 4'd7;

    localparam int CB_RST  = 0;
    localparam int CB_MODE = 5;
endpackage

// File: rtl/smem_cfg_regs.sv
`timescale 1ns/1ps
// Configuration registers: memory type, start block and end block.
// Produces the scaled start and end byte addresses.
// Assumes REG_W is twice DW (low and high halves written separately).
module smem_cfg_regs
    import smem_pkg::*;
#(
    parameter int DW           = 8,
    parameter int REG_W        = 16,
    parameter int HA_W         = 4,
    parameter int SHIFT_NARROW = 2,
    parameter int SHIFT_WIDE   = 5,
    parameter int BYTE_AW      = REG_W + SHIFT_WIDE
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [HA_W-1:0]    addr,
    input  logic [DW-1:0]      wdata,
    output logic [BYTE_AW-1:0] start_byte,
    output logic [BYTE_AW-1:0] end_byte
);
    localparam logic [BYTE_AW-1:0] NFILL = (BYTE_AW'(1) << SHIFT_NARROW) - BYTE_AW'(1);
    localparam logic [BYTE_AW-1:0] WFILL = (BYTE_AW'(1) << SHIFT_WIDE) - BYTE_AW'(1);

    logic [REG_W-1:0]   beg_q;
    logic [REG_W-1:0]   fin_q;
    logic [1:0]         mtype_q;
    logic               narrow;
    logic [BYTE_AW-1:0] beg_ext;
    logic [BYTE_AW-1:0] fin_ext;

    // Capture host writes into the addressed configuration field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beg_q   <= '0;
            fin_q   <= '0;
            mtype_q <= '0;
        end else if (wr_en) begin
            case (addr)
                HA_W'(RA_MTYPE): mtype_q            <= wdata[1:0];
                HA_W'(RA_BEG_L): beg_q[DW-1:0]      <= wdata;
                HA_W'(RA_BEG_H): beg_q[REG_W-1:DW]  <= wdata;
                HA_W'(RA_FIN_L): fin_q[DW-1:0]      <= wdata;
                HA_W'(RA_FIN_H): fin_q[REG_W-1:DW]  <= wdata;
                default: ;
            endcase
        end
    end

    // Scale the block registers into byte addresses by memory type.
    always_comb begin
        narrow  = (mtype_q == 2'b00);
        beg_ext = BYTE_AW'(beg_q);
        fin_ext = BYTE_AW'(fin_q);
        if (narrow) begin
            start_byte = beg_ext << SHIFT_NARROW;
            end_byte   = (fin_ext << SHIFT_NARROW) + NFILL;
        end else begin
            start_byte = beg_ext << SHIFT_WIDE;
            end_byte   = (fin_ext << SHIFT_WIDE) + WFILL;
        end
    end
endmodule

// File: rtl/smem_addr_gen.sv
`timescale 1ns/1ps
// Mode register, nibble pointer and dummy-read counter.
// Turns data-register accesses into memory requests or end-of-region hits.
// Assumes at most one of ctrl_wr, data_rd, data_wr per cycle.
module smem_addr_gen
    import smem_pkg::*;
#(
    parameter int DW      = 8,
    parameter int BYTE_AW = 21,
    parameter int NIB_AW  = BYTE_AW + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctrl_wr,
    input  logic               ctrl_rst,
    input  mode_t              ctrl_mode,
    input  logic               data_rd,
    input  logic               data_wr,
    input  logic [DW-1:0]      data_val,
    input  logic [BYTE_AW-1:0] start_byte,
    input  logic [BYTE_AW-1:0] end_byte,
    output logic               mem_en,
    output logic               mem_we,
    output logic [BYTE_AW-1:0] mem_addr,
    output logic [DW-1:0]      mem_wdata,
    output logic               xfer,
    output logic               hit_end
);
    logic [NIB_AW-1:0] nib_q, nib_d, eff, start_nib, end_nib;
    logic [1:0]        dummy_q, dummy_d;
    mode_t             mode_q, mode_d;
    logic              armed;

    // Next-state decode for mode, pointer and dummy counter.
    always_comb begin
        start_nib = {start_byte, 1'b0};
        end_nib   = {end_byte, 1'b0};
        armed     = (dummy_q != 2'd0);
        nib_d     = nib_q;
        dummy_d   = dummy_q;
        mode_d    = mode_q;
        eff       = nib_q;
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        xfer      = 1'b0;
        hit_end   = 1'b0;
        if (ctrl_wr) begin
            if (ctrl_rst) begin
                mode_d  = MODE_OFF;
                dummy_d = 2'd0;
            end else begin
                mode_d = ctrl_mode;
                if (ctrl_mode[0]) begin
                    nib_d   = start_nib;
                    dummy_d = 2'd2;
                end else begin
                    nib_d   = '0;
                    dummy_d = 2'd0;
                end
            end
        end else if (data_rd && mode_q == MODE_RD) begin
            if (armed) begin
                dummy_d = dummy_q - 2'd1;
                nib_d   = start_nib;
            end else if (nib_q == end_nib) begin
                hit_end = 1'b1;
            end else begin
                xfer   = 1'b1;
                mem_en = 1'b1;
                nib_d  = nib_q + NIB_AW'(2);
            end
        end else if (data_wr && mode_q == MODE_WR) begin
            eff     = armed ? start_nib : nib_q;
            dummy_d = 2'd0;
            if (eff == end_nib) begin
                hit_end = 1'b1;
                nib_d   = eff;
            end else begin
                xfer   = 1'b1;
                mem_en = 1'b1;
                mem_we = 1'b1;
                nib_d  = eff + NIB_AW'(2);
            end
        end
        mem_addr  = eff[NIB_AW-1:1];
        mem_wdata = data_val;
    end

    // Register the pointer, counter and mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nib_q   <= '0;
            dummy_q <= 2'd0;
            mode_q  <= MODE_OFF;
        end else begin
            nib_q   <= nib_d;
            dummy_q <= dummy_d;
            mode_q  <= mode_d;
        end
    end

    // R2
    mem_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> (mode_q == MODE_RD || mode_q == MODE_WR));
    // R7
    end_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> (mem_addr != end_byte));
    // R3
    arm_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !ctrl_rst && ctrl_mode[0]) |=>
            (dummy_q == 2'd2 && nib_q == {$past(start_byte), 1'b0}));
    // R4
    dummy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && mode_q == MODE_RD && dummy_q != 2'd0) |-> !mem_en);
endmodule

// File: rtl/smem_flags.sv
`timescale 1ns/1ps
// Status flags: ready dips for one cycle after each transfer, eos is sticky
// until a host clear, busy follows the control byte.
module smem_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic ctrl_rst,
    input  logic ctrl_go,
    input  logic eos_clr,
    input  logic xfer,
    input  logic hit_end,
    output logic ready,
    output logic eos,
    output logic busy
);
    // Update the three flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready <= 1'b1;
            eos   <= 1'b0;
            busy  <= 1'b0;
        end else begin
            ready <= !xfer;
            if (hit_end)      eos <= 1'b1;
            else if (eos_clr) eos <= 1'b0;
            if (ctrl_wr) begin
                if (ctrl_rst)     busy <= 1'b0;
                else if (ctrl_go) busy <= 1'b1;
            end
        end
    end

    // R8
    ready_dip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |=> !ready);
    // R8
    ready_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !xfer) |=> ready);
    // R7
    eos_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_end |=> eos);
    // R10
    ctrl_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && ctrl_rst) |=> (ready && !busy));
endmodule

// File: rtl/smem_port_ctrl.sv
`timescale 1ns/1ps
// Top of the register-port sample memory access controller.
// Decodes host accesses, wires the config, pointer and flag units, and
// returns read data one cycle after a data-register read.
// Assumes the memory answers a read one cycle after mem_en.
module smem_port_ctrl
    import smem_pkg::*;
#(
    parameter int DW           = 8,
    parameter int REG_W        = 16,
    parameter int HA_W         = 4,
    parameter int SHIFT_NARROW = 2,
    parameter int SHIFT_WIDE   = 5,
    localparam int BYTE_AW     = REG_W + SHIFT_WIDE,
    localparam int NIB_AW      = BYTE_AW + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic [HA_W-1:0]    host_addr,
    input  logic [DW-1:0]      host_wdata,
    output logic [DW-1:0]      host_rdata,
    output logic               host_rvalid,
    output logic               mem_en,
    output logic               mem_we,
    output logic [BYTE_AW-1:0] mem_addr,
    output logic [DW-1:0]      mem_wdata,
    input  logic [DW-1:0]      mem_rdata,
    output logic               ready,
    output logic               eos,
    output logic               busy
);
    logic               ctrl_wr, data_rd, data_wr, eos_clr;
    logic               ctrl_rst;
    mode_t              ctrl_mode;
    logic [BYTE_AW-1:0] start_byte, end_byte;
    logic               xfer, hit_end;
    logic               real_rd_q;

    // Decode host strobes against the register map.
    always_comb begin
        ctrl_wr   = host_wr && host_addr == HA_W'(RA_CTRL);
        data_wr   = host_wr && host_addr == HA_W'(RA_DATA);
        data_rd   = host_rd && host_addr == HA_W'(RA_DATA);
        eos_clr   = host_wr && host_addr == HA_W'(RA_FCLR) && host_wdata[0];
        ctrl_rst  = host_wdata[CB_RST];
        ctrl_mode = host_wdata[CB_MODE +: 3];
    end

    smem_cfg_regs #(
        .DW(DW), .REG_W(REG_W), .HA_W(HA_W),
        .SHIFT_NARROW(SHIFT_NARROW), .SHIFT_WIDE(SHIFT_WIDE), .BYTE_AW(BYTE_AW)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(host_wr), .addr(host_addr),
        .wdata(host_wdata), .start_byte(start_byte), .end_byte(end_byte)
    );

    smem_addr_gen #(.DW(DW), .BYTE_AW(BYTE_AW), .NIB_AW(NIB_AW)) u_addr (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_rst(ctrl_rst),
        .ctrl_mode(ctrl_mode), .data_rd(data_rd), .data_wr(data_wr),
        .data_val(host_wdata), .start_byte(start_byte), .end_byte(end_byte),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .xfer(xfer), .hit_end(hit_end)
    );

    smem_flags u_flags (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_rst(ctrl_rst),
        .ctrl_go(ctrl_mode[2]), .eos_clr(eos_clr), .xfer(xfer),
        .hit_end(hit_end), .ready(ready), .eos(eos), .busy(busy)
    );

    // Track which read responses carry memory data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rvalid <= 1'b0;
            real_rd_q   <= 1'b0;
        end else begin
            host_rvalid <= data_rd;
            real_rd_q   <= xfer && !mem_we;
        end
    end

    // Return memory data for real reads, zero otherwise.
    always_comb host_rdata = real_rd_q ? mem_rdata : '0;

    // R11
    rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_rd |=> host_rvalid);
    // R11
    zero_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rvalid && !real_rd_q) |-> host_rdata == '0);
endmodule

// File: tb/test_smem_port_ctrl.sv
`timescale 1ns/1ps
module test_smem_port_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [3:0]  host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        host_rvalid;
    logic        mem_en, mem_we;
    logic [20:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic        ready, eos, busy;

    int total = 0;
    int bad = 0;
    bit chk_on = 0;
    bit done = 0;

    always #2 clk = ~clk;

    smem_port_ctrl i_smem_port_ctrl (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_rvalid(host_rvalid), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .ready(ready), .eos(eos), .busy(busy)
    );

    // Sample memory model with a computed default pattern.
    logic [7:0] bmem [int];
    function automatic int mget(int a);
        if (bmem.exists(a)) return int'(bmem[a]);
        return (a * 7 + 3) & 255;
    endfunction
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) bmem[int'(mem_addr)] = mem_wdata;
            else        mem_rdata <= 8'(mget(int'(mem_addr)));
        end
    end

    function void chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endfunction

    // Behavioural reference state.
    int m_nib = 0, m_dummy = 0, m_mode = 0, m_beg = 0, m_fin = 0, m_mt = 0;
    int m_ready = 1, m_eos = 0, m_busy = 0, m_rv = 0, m_realq = 0, m_raddr = 0;
    int n_nib, n_dummy, n_mode, n_beg, n_fin, n_mt;
    int n_ready, n_eos, n_busy, n_rv, n_realq, n_raddr;
    int e_en, e_we, e_addr, e_wdata;

    function void eval();
        int sh, sb, eb, v, a, eff;
        sh = (m_mt == 0) ? 4 : 32;
        sb = m_beg * sh;
        eb = m_fin * sh + sh - 1;
        v = int'(host_wdata);
        a = int'(host_addr);
        n_nib = m_nib; n_dummy = m_dummy; n_mode = m_mode; n_beg = m_beg;
        n_fin = m_fin; n_mt = m_mt; n_eos = m_eos; n_busy = m_busy;
        e_en = 0; e_we = 0; e_addr = 0; e_wdata = v;
        if (host_wr && a == 0) begin
            if ((v & 1) != 0) begin
                n_mode = 0; n_dummy = 0; n_busy = 0;
            end else begin
                n_mode = (v >> 5) & 7;
                if ((v & 32) != 0) begin n_nib = 2 * sb; n_dummy = 2; end
                else begin n_nib = 0; n_dummy = 0; end
                if ((v & 128) != 0) n_busy = 1;
            end
        end else if (host_rd && a == 1 && m_mode == 1) begin
            if (m_dummy > 0) begin n_dummy = m_dummy - 1; n_nib = 2 * sb; end
            else if (m_nib == 2 * eb) n_eos = 1;
            else begin e_en = 1; e_addr = m_nib / 2; n_nib = m_nib + 2; end
        end else if (host_wr && a == 1 && m_mode == 3) begin
            eff = (m_dummy > 0) ? 2 * sb : m_nib;
            n_dummy = 0;
            if (eff == 2 * eb) begin n_eos = 1; n_nib = eff; end
            else begin e_en = 1; e_we = 1; e_addr = eff / 2; n_nib = eff + 2; end
        end
        if (host_wr && a == 2 && (v & 1) != 0 && n_eos == m_eos) n_eos = 0;
        if (host_wr && a == 3) n_mt = v & 3;
        if (host_wr && a == 4) n_beg = (m_beg & 'hff00) | v;
        if (host_wr && a == 5) n_beg = (m_beg & 'h00ff) | (v << 8);
        if (host_wr && a == 6) n_fin = (m_fin & 'hff00) | v;
        if (host_wr && a == 7) n_fin = (m_fin & 'h00ff) | (v << 8);
        n_ready = (e_en != 0) ? 0 : 1;
        n_rv = (host_rd && a == 1) ? 1 : 0;
        n_realq = (e_en != 0 && e_we == 0) ? 1 : 0;
        n_raddr = e_addr;
    endfunction

    // Advance the reference on every clock edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_nib = 0; m_dummy = 0; m_mode = 0; m_beg = 0; m_fin = 0; m_mt = 0;
            m_ready = 1; m_eos = 0; m_busy = 0; m_rv = 0; m_realq = 0; m_raddr = 0;
        end else begin
            eval();
            m_nib = n_nib; m_dummy = n_dummy; m_mode = n_mode; m_beg = n_beg;
            m_fin = n_fin; m_mt = n_mt; m_ready = n_ready; m_eos = n_eos;
            m_busy = n_busy; m_rv = n_rv; m_realq = n_realq; m_raddr = n_raddr;
        end
    end

    // Compare every cycle, half a period away from the active edge.
    always @(negedge clk) begin
        if (chk_on) begin
            eval();
            chk("R2 mem_en", int'(mem_en), e_en);
            if (e_en != 0) begin
                chk("R5 mem_we", int'(mem_we), e_we);
                chk("R6 mem_addr", int'(mem_addr), e_addr);
                if (e_we != 0) chk("R5 mem_wdata", int'(mem_wdata), e_wdata);
            end
            chk("R8 ready", int'(ready), m_ready);
            chk("R7 eos", int'(eos), m_eos);
            chk("R10 busy", int'(busy), m_busy);
            chk("R11 rvalid", int'(host_rvalid), m_rv);
            if (m_rv != 0)
                chk("R4 rdata", int'(host_rdata), (m_realq != 0) ? mget(m_raddr) : 0);
        end
    end

    task automatic wr(input int a, input int v);
        @(posedge clk); #1;
        host_wr = 1'b1; host_addr = 4'(a); host_wdata = 8'(v);
        @(posedge clk); #1;
        host_wr = 1'b0;
    endtask

    task automatic rd(output int d);
        @(posedge clk); #1;
        host_rd = 1'b1; host_addr = 4'd1;
        @(posedge clk); #1;
        host_rd = 1'b0;
        @(negedge clk);
        d = int'(host_rdata);
    endtask

    task automatic setup(input int mt, input int b, input int f);
        wr(3, mt);
        wr(4, b & 255); wr(5, b >> 8);
        wr(6, f & 255); wr(7, f >> 8);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int d, cnt;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ready", int'(ready), 1);
        chk("R1 eos", int'(eos), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 rvalid", int'(host_rvalid), 0);
        chk("R1 mem_en", int'(mem_en), 0);
        chk_on = 1;

        // R12 narrow map: start block 1 -> byte 4, end block 2 -> byte 11 (R9)
        setup(0, 1, 2);
        wr(0, 'h60);
        cnt = 0;
        for (int i = 0; i < 10; i++) begin
            if (eos == 1'b0) cnt++;
            wr(1, 'hA0 + i);
        end
        // R5 R6: seven bytes stored from start byte 4 before the end is hit
        chk("R9 narrow write count", cnt, 8);
        chk("R5 first byte", mget(4), 'hA0);
        chk("R6 last byte", mget(10), 'hA6);
        chk("R7 eos sticky", int'(eos), 1);
        wr(2, 0);
        chk("R7 eos held", int'(eos), 1);
        wr(2, 1);
        @(negedge clk);
        chk("R7 eos cleared", int'(eos), 0);

        // R4 R3 read mode with dummy reads
        wr(0, 'h20);
        rd(d); chk("R4 dummy one", d, 0);
        rd(d); chk("R4 dummy two", d, 0);
        rd(d); chk("R3 first real", d, 'hA0);
        cnt = 1;
        while (eos == 1'b0 && cnt < 50) begin rd(d); if (eos == 1'b0) cnt++; end
        chk("R9 narrow read count", cnt, 7);
        rd(d); chk("R7 read at end", d, 0);
        wr(2, 1);

        // R2 other modes: no memory access, zero data
        wr(0, 'h80);
        @(negedge clk); chk("R10 busy set", int'(busy), 1);
        rd(d); chk("R2 idle read", d, 0);
        wr(1, 'h55);
        chk("R2 idle write", mget(5), 'hA1);
        wr(0, 'h21);
        @(negedge clk); chk("R10 busy clear", int'(busy), 0);
        rd(d); chk("R10 mode cleared", d, 0);

        // R9 wide map: block 1 -> bytes 32..63, 31 transfers
        setup(2, 1, 1);
        wr(0, 'h20);
        rd(d); rd(d);
        cnt = 0;
        while (cnt < 60) begin
            rd(d);
            if (eos == 1'b1) break;
            chk("R6 wide data", d, mget(32 + cnt));
            cnt++;
        end
        chk("R9 wide read count", cnt, 31);
        wr(2, 1);

        // R5 write re-entry lands at start byte 32
        wr(0, 'h60);
        wr(1, 'h3C);
        wr(1, 'h3D);
        wr(0, 'h20);
        rd(d); rd(d);
        rd(d); chk("R5 rewrite start", d, 'h3C);
        rd(d); chk("R6 rewrite next", d, 'h3D);

        repeat (3) @(posedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule